// File: doc/BRIEF.md
# Single-Channel DMA Controller

This block moves a block of words between one I/O device and a synchronous memory bus so that the processor does not copy each word itself. Software programs a memory start address and a word count, then writes a control word that picks the direction and the bus-holding policy and starts the run. The engine asks for the bus only when the device has a word ready (or can take one). It drives memory only while it holds the grant, and it keeps the word in transit in an internal data register. It steps the address up and the count down for every word moved.

Two bus-holding policies are offered. In burst mode the engine keeps the bus across consecutive words for as long as the device stays ready. In cycle-stealing mode it gives the bus back after every word, so a block of N words costs N separate grants. In either mode the engine lets go of the bus whenever the device is not ready, even if words remain. When the count reaches zero the engine drops its request, clears busy and raises a level interrupt. The interrupt stays high until software reads status, writes a new count or starts a new run.

The device handshake works as follows. `dev_ready` high means the device holds a word to give (device to memory) or has room for one (memory to device). Once raised, it stays high until the engine pulses `dev_take` or `dev_put`. The bus arbiter keeps `bus_grant` high for as long as `bus_req` stays high. Memory read data appears one cycle after `mem_re`.

Top module: `dma_channel`

## Requirements
- R1: After reset, `bus_req`, `irq`, `mem_we`, `mem_re`, `dev_take` and `dev_put` are low and the status register reads zero.
- R2: Register select 0 is the address, 1 is the word count and 2 is the control word: bit 0 starts a run, bit 1 set means memory to device, bit 2 set means burst. Select 3 is status, with bit 0 busy and bit 1 done. Reads are combinational. The address keeps only its low AW bits and the count its low CW bits.
- R3: Memory and device strobes occur only while `bus_req` and `bus_grant` are both high, and at most one strobe is active per cycle.
- R4: In device-to-memory mode, word i taken from the device is written to address base+i, modulo 2^AW. The address register ends at base+N and the count at zero, and each moved word lowers the count by exactly one.
- R5: In memory-to-device mode, the device receives the memory words at base, base+1, ... in order.
- R6: In burst mode, with the device ready throughout, a block costs exactly one bus grant.
- R7: In burst mode, if the device is not ready before the grant, `bus_req` is dropped in the next cycle. A mid-block pause by the device releases the bus and later re-requests it, and the block still completes.
- R8: In cycle-stealing mode, `bus_req` is low in the cycle after every moved word, so N words take N grants.
- R9: On completion, `bus_req` is low when `irq` rises, status shows done and not busy, and `irq` stays high.
- R10: Done and `irq` are cleared by a status read, or by a count write while idle.
- R11: While busy, writes to address, count and control have no effect on the run in progress or on the final register values.
- R12: Starting with a count of zero sets done and `irq` at once and never raises `bus_req`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_sel | input | 2 | Register select |
| reg_wr | input | 1 | Register write strobe |
| reg_rd | input | 1 | Register read strobe (clears done on status) |
| reg_wdata | input | DW | Register write data |
| reg_rdata | output | DW | Register read data |
| bus_req | output | 1 | Bus request to the arbiter |
| bus_grant | input | 1 | Bus grant from the arbiter |
| mem_addr | output | AW | Memory address |
| mem_we | output | 1 | Memory write strobe |
| mem_re | output | 1 | Memory read strobe |
| mem_wdata | output | DW | Memory write data |
| mem_rdata | input | DW | Memory read data, one cycle after `mem_re` |
| dev_ready | input | 1 | Device has a word or has room for one |
| dev_rdata | input | DW | Word offered by the device |
| dev_take | output | 1 | Engine consumes `dev_rdata` |
| dev_wdata | output | DW | Word delivered to the device |
| dev_put | output | 1 | Engine delivers `dev_wdata` |
| irq | output | 1 | Completion interrupt, level |

## Verification
The bench builds the engine with AW=8, CW=6 and DW=16. An 8-bit address lets a 256-word memory model cover the whole space, so a block that starts near the top checks the address wrap. A 6-bit count makes the truncation of an oversized count write observable. Grant delays and device pauses are drawn at random. Directed runs pin the exact grant counts: one grant for a burst with a ready device, N grants in cycle stealing, and two grants for a burst with a single device pause.

// File: rtl/dma_channel.sv
module dma_channel #(
  parameter int AW = 16,
  parameter int DW = 16,
  parameter int CW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [1:0]    reg_sel,
  input  logic          reg_wr,
  input  logic          reg_rd,
  input  logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_rdata,
  output logic          bus_req,
  input  logic          bus_grant,
  output logic [AW-1:0] mem_addr,
  output logic          mem_we,
  output logic          mem_re,
  output logic [DW-1:0] mem_wdata,
  input  logic [DW-1:0] mem_rdata,
  input  logic          dev_ready,
  input  logic [DW-1:0] dev_rdata,
  output logic          dev_take,
  output logic [DW-1:0] dev_wdata,
  output logic          dev_put,
  output logic          irq
);

  localparam logic [1:0] SEL_ADDR = 2'd0;
  localparam logic [1:0] SEL_CNT  = 2'd1;
  localparam logic [1:0] SEL_CTL  = 2'd2;
  localparam logic [1:0] SEL_STAT = 2'd3;

  typedef enum logic [2:0] {
    S_IDLE, S_WAIT, S_REQ, S_FETCH, S_LATCH, S_STORE, S_HOLD
  } state_t;

  state_t        state_q;
  logic [AW-1:0] addr_q;
  logic [CW-1:0] cnt_q;
  logic [DW-1:0] data_q;
  logic          to_dev_q, burst_q, done_q;

  wire busy    = (state_q != S_IDLE);
  wire wr_addr = reg_wr && reg_sel == SEL_ADDR && !busy;
  wire wr_cnt  = reg_wr && reg_sel == SEL_CNT  && !busy;
  wire wr_ctl  = reg_wr && reg_sel == SEL_CTL  && !busy;
  wire start   = wr_ctl && reg_wdata[0];
  wire rd_stat = reg_rd && reg_sel == SEL_STAT;
  wire step    = (state_q == S_STORE);
  wire last    = (cnt_q == CW'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
    end else begin
      case (state_q)
        S_IDLE:  if (start && cnt_q != '0) state_q <= S_WAIT;
        S_WAIT:  if (dev_ready) state_q <= S_REQ;
        S_REQ:   if (!dev_ready) state_q <= S_WAIT;
                 else if (bus_grant) state_q <= S_FETCH;
        S_FETCH: state_q <= to_dev_q ? S_LATCH : S_STORE;
        S_LATCH: state_q <= S_STORE;
        S_STORE: state_q <= last ? S_IDLE : (burst_q ? S_HOLD : S_WAIT);
        S_HOLD:  state_q <= dev_ready ? S_FETCH : S_WAIT;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (wr_addr)   addr_q <= reg_wdata[AW-1:0];
      else if (step) addr_q <= addr_q + 1'b1;
      if (wr_cnt)    cnt_q  <= reg_wdata[CW-1:0];
      else if (step) cnt_q  <= cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      to_dev_q <= 1'b0;
      burst_q  <= 1'b0;
    end else if (wr_ctl) begin
      to_dev_q <= reg_wdata[1];
      burst_q  <= reg_wdata[2];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                data_q <= '0;
    else if (state_q == S_FETCH && !to_dev_q) data_q <= dev_rdata;
    else if (state_q == S_LATCH)              data_q <= mem_rdata;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                  done_q <= 1'b0;
    else if (start)              done_q <= (cnt_q == '0);
    else if (step && last)       done_q <= 1'b1;
    else if (rd_stat || wr_cnt)  done_q <= 1'b0;
  end

  assign bus_req   = busy && state_q != S_WAIT;
  assign mem_re    = state_q == S_FETCH &&  to_dev_q;
  assign dev_take  = state_q == S_FETCH && !to_dev_q;
  assign mem_we    = step && !to_dev_q;
  assign dev_put   = step &&  to_dev_q;
  assign mem_addr  = addr_q;
  assign mem_wdata = data_q;
  assign dev_wdata = data_q;
  assign irq       = done_q;

  always_comb begin
    reg_rdata = '0;
    case (reg_sel)
      SEL_ADDR: reg_rdata[AW-1:0] = addr_q;
      SEL_CNT:  reg_rdata[CW-1:0] = cnt_q;
      SEL_CTL:  reg_rdata[2:0]    = {burst_q, to_dev_q, 1'b0};
      default:  reg_rdata[1:0]    = {done_q, busy};
    endcase
  end

endmodule

// File: rtl/dma_channel_chk.sv
module dma_channel_chk #(
  parameter int CW = 16
) (
  input logic          clk,
  input logic          rst_n,
  input logic          bus_req,
  input logic          bus_grant,
  input logic          dev_ready,
  input logic          mem_we,
  input logic          mem_re,
  input logic          dev_take,
  input logic          dev_put,
  input logic          irq,
  input logic          burst,
  input logic [CW-1:0] cnt
);

  wire strobe = mem_we || mem_re || dev_take || dev_put;
  wire moved  = mem_we || dev_put;

  // R3
  strobe_grant_chk: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |-> (bus_req && bus_grant));

  // R3
  strobe_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_we, mem_re, dev_take, dev_put}));

  // R4
  count_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    moved |=> (cnt == CW'($past(cnt) - 1'b1)));

  // R7
  notready_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_req && !bus_grant && !dev_ready) |=> !bus_req);

  // R8
  steal_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (moved && !burst) |=> !bus_req);

  // R9
  irq_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(irq) |-> !bus_req);

endmodule

bind dma_channel dma_channel_chk #(.CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_req(bus_req), .bus_grant(bus_grant),
  .dev_ready(dev_ready), .mem_we(mem_we), .mem_re(mem_re),
  .dev_take(dev_take), .dev_put(dev_put), .irq(irq),
  .burst(burst_q), .cnt(cnt_q)
);

// File: tb/dma_channel_bench.sv
`timescale 1ns/1ps
module dma_channel_bench;
  localparam int AW = 8;
  localparam int DW = 16;
  localparam int CW = 6;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [1:0] reg_sel = '0;
  logic reg_wr = 1'b0, reg_rd = 1'b0;
  logic [DW-1:0] reg_wdata = '0, reg_rdata;
  logic bus_req, bus_grant, mem_we, mem_re, dev_take, dev_put, irq;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_wdata, mem_rdata, dev_rdata, dev_wdata;
  logic dev_ready;

  int checks = 0, errors = 0;
  bit finished = 0;
  bit arm = 0;
  int salt = 0, dev_mode = 0, gap_at = 0;
  int sidx, pidx, nwords, low_left, gcnt, reqcyc, gwait;
  logic [DW-1:0] mem [0:255];
  logic [DW-1:0] sink [0:63];

  always #2.5 clk = ~clk;

  dma_channel #(.AW(AW), .DW(DW), .CW(CW)) u_dma_channel (
    .clk(clk), .rst_n(rst_n), .reg_sel(reg_sel), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_req(bus_req),
    .bus_grant(bus_grant), .mem_addr(mem_addr), .mem_we(mem_we), .mem_re(mem_re),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata), .dev_ready(dev_ready),
    .dev_rdata(dev_rdata), .dev_take(dev_take), .dev_wdata(dev_wdata),
    .dev_put(dev_put), .irq(irq));

  function automatic logic [DW-1:0] mem_pat(int a, int s);
    return DW'((a * 97 + s * 13) ^ 16'h5A3C);
  endfunction
  function automatic logic [DW-1:0] dev_word(int i, int s);
    return DW'((i * 211 + s * 7 + 1) ^ 16'hC3A5);
  endfunction

  assign dev_rdata = dev_word(sidx, salt);

  // arbiter: grants after a random delay, holds while requested
  always @(posedge clk) begin
    if (!rst_n) begin
      bus_grant <= 1'b0; gwait <= 0;
    end else if (!bus_req) begin
      bus_grant <= 1'b0; gwait <= int'($urandom % 4);
    end else if (!bus_grant) begin
      if (gwait == 0) bus_grant <= 1'b1; else gwait <= gwait - 1;
    end
    if (arm) gcnt <= 0;
    else if (rst_n && bus_req && !bus_grant && gwait == 0) gcnt <= gcnt + 1;
  end

  // memory and device models
  always @(posedge clk) begin
    if (arm) begin
      for (int i = 0; i < 256; i++) mem[i] <= mem_pat(i, salt);
      sidx <= 0; pidx <= 0; nwords <= 0; reqcyc <= 0; low_left <= 0;
      dev_ready <= (dev_mode != 1);
    end else begin
      if (mem_we) mem[mem_addr] <= mem_wdata;
      if (mem_re) mem_rdata <= mem[mem_addr];
      if (bus_req) reqcyc <= reqcyc + 1;
      if (dev_take) sidx <= sidx + 1;
      if (dev_put) begin sink[pidx[5:0]] <= dev_wdata; pidx <= pidx + 1; end
      if (dev_take || dev_put) begin
        nwords <= nwords + 1;
        if (dev_mode == 1) dev_ready <= 1'($urandom % 2);
        else if (dev_mode == 2 && nwords + 1 == gap_at) begin
          dev_ready <= 1'b0; low_left <= 3;
        end
      end else if (!dev_ready) begin
        if (dev_mode == 1) begin
          if ($urandom % 3 == 0) dev_ready <= 1'b1;
        end else if (low_left <= 1) dev_ready <= 1'b1;
        else low_left <= low_left - 1;
      end
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic wreg(input logic [1:0] s, input logic [DW-1:0] d);
    @(negedge clk); reg_sel = s; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk); reg_wr = 1'b0;
  endtask

  task automatic rreg(input logic [1:0] s, output logic [DW-1:0] d);
    @(negedge clk); reg_sel = s; reg_rd = 1'b1; #1 d = reg_rdata;
    @(negedge clk); reg_rd = 1'b0;
  endtask

  task automatic prep(input int mode);
    salt = int'($urandom % 1000); dev_mode = mode;
    @(negedge clk); arm = 1'b1; @(negedge clk); arm = 1'b0;
  endtask

  task automatic start(input bit to_dev, input bit burst, input int base, input int n);
    wreg(2'd0, DW'(base)); wreg(2'd1, DW'(n));
    wreg(2'd2, DW'({burst, to_dev, 1'b1}));
  endtask

  task automatic wait_irq(input string tag);
    int t = 0;
    while (!irq && t < 20000) begin @(negedge clk); t++; end
    check(irq == 1'b1, tag, int'(irq), 1);
  endtask

  task automatic verify(input bit to_dev, input int base, input int n,
                        input int gmin, input int gmax, input string tag);
    logic [DW-1:0] v;
    int bad = 0;
    for (int i = 0; i < n; i++) begin
      if (!to_dev && mem[(base + i) % 256] != dev_word(i, salt)) bad++;
      if (to_dev && sink[i] != mem_pat((base + i) % 256, salt)) bad++;
    end
    check(bad == 0, to_dev ? "R5 device data" : "R4 memory data", bad, 0);
    if (!to_dev)
      check(mem[(base + n) % 256] == mem_pat((base + n) % 256, salt),
            "R4 neighbour untouched", int'(mem[(base + n) % 256]),
            int'(mem_pat((base + n) % 256, salt)));
    check(gcnt >= gmin && gcnt <= gmax, tag, gcnt, gmin);
    rreg(2'd0, v); check(int'(v) == (base + n) % 256, "R4 final address", int'(v), (base + n) % 256);
    rreg(2'd1, v); check(v == 0, "R9 final count", int'(v), 0);
    rreg(2'd3, v); check(v == 2, "R9 status done", int'(v), 2);
    check(irq == 1'b0, "R10 irq cleared by status read", int'(irq), 0);
  endtask

  task automatic run(input bit to_dev, input bit burst, input int mode, input int base,
                     input int n, input int gmin, input int gmax, input string tag);
    prep(mode);
    start(to_dev, burst, base, n);
    wait_irq("R9 irq raised");
    verify(to_dev, base, n, gmin, gmax, tag);
  endtask

  initial begin
    logic [DW-1:0] v;
    void'($urandom(32'd7));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1
    check({bus_req, irq, mem_we, mem_re, dev_take, dev_put} == 6'b0, "R1 outputs idle",
          int'({bus_req, irq, mem_we, mem_re, dev_take, dev_put}), 0);
    rreg(2'd3, v); check(v == 0, "R1 status zero", int'(v), 0);

    // R2: address keeps 8 bits, count 6 bits
    wreg(2'd0, 16'h1234); rreg(2'd0, v); check(v == 16'h0034, "R2 address readback", int'(v), 'h34);
    wreg(2'd1, 16'h00FF); rreg(2'd1, v); check(v == 16'h003F, "R2 count readback", int'(v), 'h3F);
    wreg(2'd2, 16'h0006); rreg(2'd2, v); check(v == 16'h0006, "R2 control readback", int'(v), 6);

    // R12 zero count, then R10 clear paths
    prep(0);
    wreg(2'd1, 16'd0); wreg(2'd2, 16'h0001);
    check(irq == 1'b1, "R12 immediate irq", int'(irq), 1);
    check(reqcyc == 0, "R12 no bus request", reqcyc, 0);
    rreg(2'd3, v); check(v == 2, "R12 status done", int'(v), 2);
    rreg(2'd3, v); check(v == 0, "R10 done cleared by read", int'(v), 0);
    wreg(2'd2, 16'h0001);
    check(irq == 1'b1, "R12 irq again", int'(irq), 1);
    wreg(2'd1, 16'd5);
    check(irq == 1'b0, "R10 irq cleared by count write", int'(irq), 0);

    // directed runs
    run(1'b0, 1'b1, 0, 16'h10, 8, 1, 1, "R6 burst d2m one grant");
    run(1'b1, 1'b1, 0, 16'h40, 7, 1, 1, "R6 burst m2d one grant");
    run(1'b0, 1'b0, 0, 16'h20, 6, 6, 6, "R8 steal d2m grants");
    run(1'b1, 1'b0, 1, 16'h60, 5, 5, 5, "R8 steal m2d grants");
    gap_at = 3;
    run(1'b0, 1'b1, 2, 16'h30, 6, 2, 2, "R7 burst pause two grants");
    run(1'b0, 1'b1, 0, 16'hFC, 8, 1, 1, "R4 address wrap grants");

    // R11: writes while busy are ignored
    prep(1);
    start(1'b0, 1'b0, 16'h80, 12);
    rreg(2'd3, v); check(v[0] == 1'b1, "R11 busy during run", int'(v[0]), 1);
    wreg(2'd0, 16'h0000); wreg(2'd1, 16'd3); wreg(2'd2, 16'h0007);
    wait_irq("R11 irq raised");
    verify(1'b0, 16'h80, 12, 12, 12, "R11 steal kept despite control write");

    // random mix
    for (int k = 0; k < 8; k++) begin
      bit d = 1'($urandom % 2), b = 1'($urandom % 2);
      int m = int'($urandom % 2), n = 1 + int'($urandom % 20), base = int'($urandom % 256);
      if (!b) run(d, b, m, base, n, n, n, "R8 random steal grants");
      else if (m == 0) run(d, b, m, base, n, 1, 1, "R6 random burst grants");
      else run(d, b, m, base, n, 1, n, "R7 random burst grants");
    end

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule